// File: doc/BRIEF.md
# Hardware Page Table Walker

This block turns a 20-bit virtual page number into an 18-bit physical page number by fetching one entry of a single-level page table kept in main memory. A translation request carries the page number and a flag saying whether the access is a store. The walker adds four times the page number to the table base. It issues exactly one read on a request/response memory port and inspects the returned 32-bit entry. It then reports either a fill or a page fault. The caller forms the 30-bit physical address itself by placing the returned page number above the untranslated 12-bit offset.

An entry holds its physical page number in bits 17:0, a store-permission flag in bit 30 and a resident flag in bit 31; bits 29:18 are ignored. A cleared resident flag means the page sits in backing storage. The walker then raises a fault for the operating system to service, and it does not retry. The table base lives in a register that only supervisor mode may load, so that it can be swapped with each process's context.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready_o is 1, resp_valid_o, mem_req_valid_o and base_rej_o are 0, and the table base is 0, so the first walk reads address vpn*4.
- R2: While mem_req_valid_o is 1, mem_addr_o equals (base + vpn*4) mod 2^32, and address and request stay unchanged until a cycle with mem_req_ready_i high.
- R3: Each translation makes exactly one memory request handshake; mem_req_valid_o stays 0 while the response is awaited and after it.
- R4: If the returned entry has bit 31 set, the response carries resp_fault_o=0, resp_ppn_o equal to entry bits 17:0 and resp_wr_en_o equal to entry bit 30.
- R5: If entry bit 31 is clear, the response carries resp_fault_o=1, resp_ppn_o=0, resp_wr_en_o=0 and resp_prot_o=0.
- R6: resp_prot_o is 1 exactly when a store request (req_write_i=1) hits a resident entry whose bit 30 is 0; loads never set it.
- R7: resp_valid_o is high for exactly one cycle, in the cycle after the one in which mem_rsp_valid_i is sampled high.
- R8: req_ready_o falls in the cycle after a request is accepted and returns only after the response cycle; requests presented while busy are ignored and cause no memory access.
- R9: A base write with base_sup_i=1 loads the base register, and later walks use the new base.
- R10: A base write with base_sup_i=0 leaves the base unchanged and pulses base_rej_o for one cycle in the following cycle.
- R11: The base is sampled when a request is accepted; a base change during a walk does not alter that walk's address.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle and accepting |
| req_vpn_i | input | 20 | Virtual page number |
| req_write_i | input | 1 | Request is a store |
| base_we_i | input | 1 | Base register write strobe |
| base_sup_i | input | 1 | Writer is in supervisor mode |
| base_data_i | input | 32 | New table base address |
| base_rej_o | output | 1 | User-mode base write refused |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_addr_o | output | 32 | Entry byte address |
| mem_rsp_valid_i | input | 1 | Entry data returned |
| mem_rsp_data_i | input | 32 | Entry contents |
| resp_valid_o | output | 1 | Result present (one cycle) |
| resp_fault_o | output | 1 | Page not resident |
| resp_ppn_o | output | 18 | Physical page number |
| resp_wr_en_o | output | 1 | Page allows stores |
| resp_prot_o | output | 1 | Store to a read-only page |

## Verification
The assertions assume the memory side behaves as a single-outstanding port: mem_rsp_valid_i is only raised after the read was accepted and while the walker waits, and only once per read. They also assume the base strobe is never held across a reset release. The bench acts as that memory, granting after a chosen stall and answering after a chosen latency with one response pulse. It pokes requests and base writes only at the points the requirements name, so every interaction stays inside the legal protocol.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  localparam int PTE_RES_BIT = 31;
  localparam int PTE_WR_BIT  = 30;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          sup_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] base_o,
  output logic          rej_o
);
  logic [AW-1:0] base_q;
  logic          rej_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      rej_q  <= 1'b0;
    end else begin
      rej_q <= we_i & ~sup_i;
      if (we_i && sup_i) base_q <= data_i;
    end
  end

  assign base_o = base_q;
  assign rej_o  = rej_q;

  p_sup_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sup_i) |=> (base_o == $past(data_i)));
  p_user_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sup_i) |=> ($stable(base_o) && rej_o));
  p_rej_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rej_o |-> $past(we_i && !sup_i));
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int AW          = 32,
  parameter int VPN_W       = 20,
  parameter int ENTRY_BYTES = 4
) (
  input  logic [AW-1:0]    base_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic [AW-1:0]    addr_o
);
  localparam int SHIFT = $clog2(ENTRY_BYTES);

  assign addr_o = base_i + (AW'(vpn_i) << SHIFT);
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32,
  parameter int PPN_W = 18
) (
  input  logic [PTE_W-1:0] pte_i,
  output logic             res_o,
  output logic             wr_o,
  output logic [PPN_W-1:0] ppn_o
);
  logic unused_rsvd;

  assign res_o       = pte_i[PTE_RES_BIT];
  assign wr_o        = pte_i[PTE_WR_BIT];
  assign ppn_o       = pte_i[PPN_W-1:0];
  assign unused_rsvd = ^pte_i[PTE_W-3:PPN_W];
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int PPN_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [AW-1:0]    entry_addr_i,
  output logic             req_ready_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic             pte_res_i,
  input  logic             pte_wr_i,
  input  logic [PPN_W-1:0] pte_ppn_i,
  output logic             resp_valid_o,
  output logic             resp_fault_o,
  output logic [PPN_W-1:0] resp_ppn_o,
  output logic             resp_wr_en_o,
  output logic             resp_prot_o
);
  walk_state_e      state_q, state_d;
  logic [AW-1:0]    addr_q;
  logic             store_q;
  logic [PPN_W-1:0] ppn_q;
  logic             wr_q;
  logic             prot_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_REQ;
      ST_REQ:   if (mem_req_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid_i) state_d = pte_res_i ? ST_DONE : ST_FAULT;
      ST_DONE:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      store_q <= 1'b0;
      ppn_q   <= '0;
      wr_q    <= 1'b0;
      prot_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      // base sampled at accept
      if (state_q == ST_IDLE && req_valid_i) begin
        addr_q  <= entry_addr_i;
        store_q <= req_write_i;
      end
      if (state_q == ST_WAIT && mem_rsp_valid_i) begin
        if (pte_res_i) begin
          ppn_q  <= pte_ppn_i;
          wr_q   <= pte_wr_i;
          prot_q <= store_q & ~pte_wr_i;
        end else begin
          ppn_q  <= '0;
          wr_q   <= 1'b0;
          prot_q <= 1'b0;
        end
      end
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_addr_o      = addr_q;
  assign resp_valid_o    = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign resp_fault_o    = (state_q == ST_FAULT);
  assign resp_ppn_o      = ppn_q;
  assign resp_wr_en_o    = wr_q;
  assign resp_prot_o     = (state_q == ST_DONE) & prot_q;

  p_busy_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));
  p_resp_follows_rsp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(mem_rsp_valid_i));
  p_resp_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
  p_no_req_on_resp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (!mem_req_valid_o && !req_ready_o));
  p_fault_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_fault_o) |-> (resp_ppn_o == '0 && !resp_wr_en_o && !resp_prot_o));
  p_prot_qualified_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_prot_o |-> (resp_valid_o && !resp_fault_o && !resp_wr_en_o));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int AW          = 32,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 18,
  parameter int PTE_W       = 32,
  parameter int ENTRY_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic             req_write_i,
  input  logic             base_we_i,
  input  logic             base_sup_i,
  input  logic [AW-1:0]    base_data_i,
  output logic             base_rej_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output logic             resp_valid_o,
  output logic             resp_fault_o,
  output logic [PPN_W-1:0] resp_ppn_o,
  output logic             resp_wr_en_o,
  output logic             resp_prot_o
);
  logic [AW-1:0]    base;
  logic [AW-1:0]    entry_addr;
  logic             pte_res;
  logic             pte_wr;
  logic [PPN_W-1:0] pte_ppn;

  ptw_base_reg #(.AW(AW)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (base_we_i),
    .sup_i  (base_sup_i),
    .data_i (base_data_i),
    .base_o (base),
    .rej_o  (base_rej_o)
  );

  ptw_addr_gen #(.AW(AW), .VPN_W(VPN_W), .ENTRY_BYTES(ENTRY_BYTES)) u_addr (
    .base_i (base),
    .vpn_i  (req_vpn_i),
    .addr_o (entry_addr)
  );

  ptw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_dec (
    .pte_i (mem_rsp_data_i),
    .res_o (pte_res),
    .wr_o  (pte_wr),
    .ppn_o (pte_ppn)
  );

  ptw_fsm #(.AW(AW), .PPN_W(PPN_W)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_write_i     (req_write_i),
    .entry_addr_i    (entry_addr),
    .req_ready_o     (req_ready_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_addr_o      (mem_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .pte_res_i       (pte_res),
    .pte_wr_i        (pte_wr),
    .pte_ppn_i       (pte_ppn),
    .resp_valid_o    (resp_valid_o),
    .resp_fault_o    (resp_fault_o),
    .resp_ppn_o      (resp_ppn_o),
    .resp_wr_en_o    (resp_wr_en_o),
    .resp_prot_o     (resp_prot_o)
  );
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  typedef struct {
    logic        fault;
    logic [17:0] ppn;
    logic        wr;
    logic        prot;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic        req_write = 1'b0;
  logic        base_we = 1'b0;
  logic        base_sup = 1'b0;
  logic [31:0] base_data = '0;
  logic        base_rej;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        resp_valid;
  logic        resp_fault;
  logic [17:0] resp_ppn;
  logic        resp_wr_en;
  logic        resp_prot;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [31:0] base_m = '0;
  exp_t sb[$];

  always #4 clk = ~clk;

  ptw_walker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vpn_i(req_vpn), .req_write_i(req_write),
    .base_we_i(base_we), .base_sup_i(base_sup), .base_data_i(base_data),
    .base_rej_o(base_rej),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_addr_o(mem_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data),
    .resp_valid_o(resp_valid), .resp_fault_o(resp_fault),
    .resp_ppn_o(resp_ppn), .resp_wr_en_o(resp_wr_en), .resp_prot_o(resp_prot)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each result
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R7", "unexpected response", 32'(resp_valid), 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(resp_fault == e.fault, "R5", "fault", 32'(resp_fault), 32'(e.fault));
        chk(resp_ppn == e.ppn, "R4", "ppn", 32'(resp_ppn), 32'(e.ppn));
        chk(resp_wr_en == e.wr, "R4", "wr_en", 32'(resp_wr_en), 32'(e.wr));
        chk(resp_prot == e.prot, "R6", "prot", 32'(resp_prot), 32'(e.prot));
      end
    end
  end

  task automatic write_base(input logic [31:0] d, input logic sup);
    base_we = 1'b1; base_sup = sup; base_data = d;
    @(negedge clk);
    base_we = 1'b0;
    if (sup) base_m = d;
    chk(base_rej == !sup, sup ? "R9" : "R10", "rej pulse", 32'(base_rej), 32'(!sup));
    @(negedge clk);
    chk(base_rej == 1'b0, "R10", "rej single cycle", 32'(base_rej), 32'd0);
  endtask

  task automatic walk(input logic [19:0] vpn, input logic wr, input logic [31:0] pte,
                      input int stall, input int lat, input bit poke, input bit mid,
                      input logic [31:0] nb);
    logic [31:0] ea;
    exp_t e;
    ea = base_m + (32'(vpn) << 2);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vpn = vpn; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8", "ready low after accept", 32'(req_ready), 32'd0);
    for (int i = 0; i <= stall; i++) begin
      chk(mem_req_valid, "R2", "request held", 32'(mem_req_valid), 32'd1);
      chk(mem_addr == ea, mid ? "R11" : "R2", "entry address", mem_addr, ea);
      if (i == 0 && mid) begin
        base_we = 1'b1; base_sup = 1'b1; base_data = nb; base_m = nb;
      end
      if (i == stall) mem_req_ready = 1'b1;
      @(negedge clk);
      base_we = 1'b0;
    end
    mem_req_ready = 1'b0;
    for (int i = 0; i < lat; i++) begin
      chk(!mem_req_valid, "R3", "no second read", 32'(mem_req_valid), 32'd0);
      if (poke) begin
        req_valid = 1'b1; req_vpn = ~vpn;
        chk(!req_ready, "R8", "ready low while busy", 32'(req_ready), 32'd0);
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
    e.fault = ~pte[31];
    e.ppn   = pte[31] ? pte[17:0] : 18'd0;
    e.wr    = pte[31] & pte[30];
    e.prot  = pte[31] & wr & ~pte[30];
    sb.push_back(e);
    mem_rsp_valid = 1'b1; mem_rsp_data = pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    chk(resp_valid, "R7", "result one cycle after data", 32'(resp_valid), 32'd1);
    @(negedge clk);
    chk(!resp_valid, "R7", "result lasts one cycle", 32'(resp_valid), 32'd0);
    chk(req_ready, "R8", "ready after result", 32'(req_ready), 32'd1);
    chk(!mem_req_valid, "R3", "no extra read", 32'(mem_req_valid), 32'd0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        chk(1'b0, "R1", "watchdog", 32'(cycles), 32'd100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1", "reset ready", 32'(req_ready), 32'd1);
    chk(!resp_valid, "R1", "reset resp", 32'(resp_valid), 32'd0);
    chk(!mem_req_valid, "R1", "reset mem req", 32'(mem_req_valid), 32'd0);
    chk(!base_rej, "R1", "reset rej", 32'(base_rej), 32'd0);
    // R1: base 0 -> address vpn*4
    walk(20'h00005, 1'b0, 32'hC000_1234, 0, 0, 0, 0, '0);
    // R9 supervisor load, R4 valid fill, stalls
    write_base(32'h0010_0000, 1'b1);
    walk(20'hFFFFF, 1'b1, 32'hC003_ABCD, 2, 3, 0, 0, '0);
    // R5 non-resident entry with other bits set
    walk(20'h00123, 1'b0, 32'h4003_FFFF, 1, 1, 0, 0, '0);
    // R6 store to read-only, then load to same
    walk(20'h00200, 1'b1, 32'h8002_AAAA, 0, 2, 0, 0, '0);
    walk(20'h00200, 1'b0, 32'h8002_AAAA, 0, 2, 0, 0, '0);
    // R5 store to non-resident: no protection flag
    walk(20'h00201, 1'b1, 32'h0001_0001, 0, 0, 0, 0, '0);
    // R10 user write refused; base stays
    write_base(32'hDEAD_0000, 1'b0);
    walk(20'h00001, 1'b0, 32'h8000_0042, 0, 0, 0, 0, '0);
    // R8 requests while busy are ignored
    walk(20'h0ABCD, 1'b0, 32'hBFFF_0003, 1, 4, 1, 0, '0);
    // R11 base changed mid-walk; next walk uses new base
    walk(20'h00010, 1'b1, 32'hC000_0777, 3, 1, 0, 1, 32'h0200_0000);
    walk(20'h00010, 1'b0, 32'h8000_0778, 0, 0, 0, 0, '0);
    // R2 wraparound of base + vpn*4
    write_base(32'hFFFF_FFF0, 1'b1);
    walk(20'h00008, 1'b0, 32'hC000_0001, 0, 1, 0, 0, '0);
    for (int k = 1; k <= 12; k++) begin
      walk(20'(k * 32'h1357), k[0], {k[1], k[2], 12'h0, 18'(k * 32'h2E5)}, k % 3, k % 4, 0, 0, '0);
    end
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R7", "all results seen", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule